// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous static RAM with a built-in burst address generator. Every control, address and write-data input is captured in an input register on the rising clock edge. The captured command is decoded in the next cycle. A read leaves through an output register. The read data can therefore be sampled one clock after the edge that captured its address, and each later word of a burst follows one clock after the previous one. An output enable gates the registered data asynchronously.

A burst starts when either of two address strobes is sampled with the device selected. One strobe is meant for a processor and the other for a memory controller. After the start, a burst-advance input steps a two-bit counter. The counter rewrites only the two least-significant address bits, in either interleaved order (start XOR count) or linear order (start plus count, modulo 4). When no strobe and no advance is sampled, the current address is accessed again. Writes go through per-lane byte enables, a byte-write enable and a global write. The array is a small register memory whose size is set by parameters.

Top module: `sram_burst_pipe`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_drive` is 0 and `rd_data` is all zeros until a read has been performed. The memory contents reset to zero.
- R2: A read started at clock edge k (strobe sampled with the device selected and no write lanes) drives `rd_drive`=1 and that address's word on `rd_data` after edge k+1. Each further read of the burst appears one edge later.
- R3: With `burst_linear`=0, the burst addresses are {start[ADDR_W-1:2], start[1:0] XOR count}, with count 0,1,2,3.
- R4: With `burst_linear`=1, the burst addresses are {start[ADDR_W-1:2], (start[1:0] + count) mod 4}. The upper address bits never change.
- R5: After four words, advancing wraps the count back to 0 and repeats the same address sequence.
- R6: When the device is in a burst and no strobe and no advance is sampled, the current burst address is accessed again (a read repeats the same word).
- R7: `wr_all`=1 writes every lane. Otherwise, when `lane_wr_en`=1, only the lanes whose bit in `lane_we` is 1 are written (bit i covers `wdata[8i+7:8i]`). When no lane is selected, the cycle is a read. A write cycle does not drive `rd_data`.
- R8: A cycle started by `proc_strobe` is always a read, whatever the write inputs are. The memory is not changed.
- R9: `proc_strobe` sampled with `en_a`=0 is ignored: the burst in progress continues exactly as if no strobe had been sampled.
- R10: The device is selected only when `en_a`=1, `en_b`=1 and `en_c_n`=0. A strobe sampled while the device is not selected makes `rd_drive` 0 after the next edge, and later advances do nothing until a new selected strobe.
- R11: `out_en`=0 forces `rd_drive` to 0 and `rd_data` to zero at once, without waiting for a clock edge.
- R12: A read of an address that was written by the immediately preceding command returns the newly written bytes.
- R13: `ctrl_strobe` sampled with the device selected loads a new address and starts a burst. Its cycle, and every advance or repeat cycle, is a read or a write according to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, used by a strobe |
| wdata | input | LANES*LANE_W | Write data |
| proc_strobe | input | 1 | Processor address strobe (read-only start) |
| ctrl_strobe | input | 1 | Controller address strobe |
| burst_adv | input | 1 | Step the burst counter |
| en_a | input | 1 | Chip enable, active high, also gates proc_strobe |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| lane_we | input | LANES | Per-lane write select |
| lane_wr_en | input | 1 | Enables lane writes |
| wr_all | input | 1 | Writes all lanes |
| burst_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| out_en | input | 1 | Asynchronous output enable |
| rd_data | output | LANES*LANE_W | Read data, zero when not driving |
| rd_drive | output | 1 | High when rd_data is actively driven |

## Verification
The bench targets start addresses whose low bits are not zero. A generator that mixes up XOR and addition, or carries into the upper bits, returns the wrong word at the second or third beat. It also holds advance through a wrap, where a counter that saturates or reloads would stall or restart wrongly. A processor strobe with writes asserted and a processor strobe with `en_a` low are both applied in the middle of a burst. Honouring the first corrupts memory; the second restarts the burst at a foreign address. Deselect and output-enable timing are checked at the exact edge and mid-cycle, so one extra register or a clocked enable shows up as a stale drive. A read immediately after a write would return old bytes if the write were committed late.

// File: rtl/sram_pkg.sv
// Package of shared types and the burst-order function.
// Assumes: burst counter is two bits wide and only touches address bits [1:0].
package sram_pkg;

    // Registered control inputs of one clock cycle.
    typedef struct packed {
        logic ps;      // processor strobe
        logic cs;      // controller strobe
        logic adv;     // burst advance
        logic en_a;
        logic en_b;
        logic en_c_n;
        logic lwe;     // lane write enable
        logic wall;    // write all lanes
        logic lin;     // linear burst order
    } ctrl_t;

    // Low address bits for a given start and count in the selected order.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       linear);
        return linear ? (start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/sram_in_reg.sv
// Input register stage: captures every synchronous input on the rising edge.
// Assumes: asynchronous active-low reset clears all commands to idle.
module sram_in_reg
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] data_d,
    input  logic [LANES-1:0]  lane_d,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [LANES-1:0]  lane_q
);

    // Capture the inputs of the current cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            lane_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            addr_q <= addr_d;
            data_q <= data_d;
            lane_q <= lane_d;
        end
    end

endmodule

// File: rtl/sram_burst_ctl.sv
// Burst controller: decodes the registered command, keeps the burst base and
// two-bit count, and issues at most one array operation per cycle.
// Assumes: ADDR_W > 2; a processor strobe needs en_a high to count at all.
module sram_burst_ctl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [LANES-1:0]  lane_q,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_wmask,
    output logic              op_read
);

    logic              active_q, active_n;
    logic [ADDR_W-1:0] base_q, base_n;
    logic [1:0]        cnt_q, cnt_n;
    logic              sel, proc_go, strobe, op_valid;
    logic [LANES-1:0]  wmask, mask_n;

    // Decode the command and compute the next burst state.
    always_comb begin
        sel      = ctrl_q.en_a & ctrl_q.en_b & ~ctrl_q.en_c_n;
        proc_go  = ctrl_q.ps & ctrl_q.en_a;
        strobe   = proc_go | ctrl_q.cs;
        wmask    = ctrl_q.wall ? '1 : (ctrl_q.lwe ? lane_q : '0);
        active_n = active_q;
        base_n   = base_q;
        cnt_n    = cnt_q;
        op_valid = 1'b0;
        mask_n   = '0;
        if (strobe) begin
            if (sel) begin
                active_n = 1'b1;
                base_n   = addr_q;
                cnt_n    = 2'd0;
                op_valid = 1'b1;
                mask_n   = proc_go ? '0 : wmask;
            end else begin
                active_n = 1'b0;
            end
        end else if (active_q) begin
            if (ctrl_q.adv) begin
                cnt_n = cnt_q + 2'd1;
            end
            op_valid = 1'b1;
            mask_n   = wmask;
        end
        op_addr  = {base_n[ADDR_W-1:2], burst_low(base_n[1:0], cnt_n, ctrl_q.lin)};
        op_wmask = op_valid ? mask_n : '0;
        op_read  = op_valid & ~(|mask_n);
    end

    // Hold the burst state between cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= 2'd0;
        end else begin
            active_q <= active_n;
            base_q   <= base_n;
            cnt_q    <= cnt_n;
        end
    end

endmodule

// File: rtl/sram_array.sv
// Register array split into byte lanes; each lane writes on its own mask bit.
// Assumes: one write address per cycle; the read port is combinational.
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  wmask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Write this lane when its mask bit is set.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    cells[i] <= '0;
                end
            end else if (wmask[l]) begin
                cells[addr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rword[l*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sram_out_stage.sv
// Output register and asynchronous output-enable gating.
// Assumes: the register keeps its last word on non-read cycles.
module sram_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_read,
    input  logic [DATA_W-1:0] rword,
    input  logic              out_en,
    output logic              drv_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    logic [DATA_W-1:0] dq_q;

    // Register read data and the drive flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= 1'b0;
            dq_q  <= '0;
        end else begin
            drv_q <= op_read;
            if (op_read) begin
                dq_q <= rword;
            end
        end
    end

    // Gate the outputs without a clock.
    always_comb begin
        rd_drive = out_en & drv_q;
        rd_data  = rd_drive ? dq_q : '0;
    end

endmodule

// File: rtl/sram_burst_pipe.sv
// Top level of the pipelined burst SRAM: input register, burst controller,
// lane array and output stage in one pipeline.
// Assumes: address captured at edge k is read out after edge k+1.
module sram_burst_pipe
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              burst_adv,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic              lane_wr_en,
    input  logic              wr_all,
    input  logic              burst_linear,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    ctrl_t             ctrl_d, ctrl_q;
    logic [ADDR_W-1:0] addr_q, op_addr;
    logic [DATA_W-1:0] data_q, rword;
    logic [LANES-1:0]  lane_q, op_wmask;
    logic              op_read, drv_q;

    // Gather the control inputs into one record.
    always_comb begin
        ctrl_d = '{ps: proc_strobe, cs: ctrl_strobe, adv: burst_adv,
                   en_a: en_a, en_b: en_b, en_c_n: en_c_n,
                   lwe: lane_wr_en, wall: wr_all, lin: burst_linear};
    end

    sram_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
        .clk(clk), .rst_n(rst_n),
        .ctrl_d(ctrl_d), .addr_d(addr), .data_d(wdata), .lane_d(lane_we),
        .ctrl_q(ctrl_q), .addr_q(addr_q), .data_q(data_q), .lane_q(lane_q)
    );

    sram_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_q(ctrl_q), .addr_q(addr_q), .lane_q(lane_q),
        .op_addr(op_addr), .op_wmask(op_wmask), .op_read(op_read)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .addr(op_addr), .wmask(op_wmask), .wdata(data_q), .rword(rword)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .op_read(op_read), .rword(rword), .out_en(out_en),
        .drv_q(drv_q), .rd_data(rd_data), .rd_drive(rd_drive)
    );

endmodule

// File: rtl/sram_burst_checker.sv
// Timing properties of the burst SRAM, relating input ports to the drive flag.
// Assumes: drive flag reflects the command captured two edges earlier.
module sram_burst_checker (
    input logic clk,
    input logic rst_n,
    input logic proc_strobe,
    input logic ctrl_strobe,
    input logic en_a,
    input logic en_b,
    input logic en_c_n,
    input logic wr_all,
    input logic out_en,
    input logic rd_drive,
    input logic drv_q
);

    logic sel;
    assign sel = en_a & en_b & ~en_c_n;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !drv_q);

    assert_proc_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe && sel) |=> ##1 drv_q);

    assert_write_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strobe && !(proc_strobe && en_a) && sel && wr_all) |=> ##1 !drv_q);

    assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (((proc_strobe && en_a) || ctrl_strobe) && !sel) |=> ##1 !drv_q);

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !rd_drive);

endmodule

bind sram_burst_pipe sram_burst_checker u_chk (
    .clk(clk), .rst_n(rst_n), .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe),
    .en_a(en_a), .en_b(en_b), .en_c_n(en_c_n), .wr_all(wr_all),
    .out_en(out_en), .rd_drive(rd_drive), .drv_q(drv_q)
);

// File: tb/test_sram_burst_pipe.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks of burst orders, writes, deselect and output enable.
module test_sram_burst_pipe;

    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [5:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic        proc_strobe = 0, ctrl_strobe = 0, burst_adv = 0;
    logic        en_a = 1, en_b = 1, en_c_n = 0;
    logic [3:0]  lane_we = 0;
    logic        lane_wr_en = 0, wr_all = 0, burst_linear = 0, out_en = 1;
    logic [31:0] rd_data;
    logic        rd_drive;

    int checks = 0;
    int errors = 0;
    string cur = "R1";

    always #4 clk = ~clk;

    sram_burst_pipe i_sram_burst_pipe (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe), .burst_adv(burst_adv),
        .en_a(en_a), .en_b(en_b), .en_c_n(en_c_n), .lane_we(lane_we),
        .lane_wr_en(lane_wr_en), .wr_all(wr_all), .burst_linear(burst_linear),
        .out_en(out_en), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    // Reference model state.
    logic [31:0] mm [NW];
    bit          m_act, e_drv;
    logic [5:0]  m_base;
    int          m_cnt;
    logic [31:0] e_dq;
    // Command seen at the previous edge.
    logic [5:0]  p_addr; logic [31:0] p_wd; logic [3:0] p_lw;
    bit p_ps, p_cs, p_adv, p_a, p_b, p_c, p_le, p_wa, p_lin;

    function automatic logic [31:0] word(input int a);
        return 32'hC0DE_0000 | a;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit sel, go_p, have;
        logic [3:0] mask;
        logic [5:0] a;
        int lo;
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mm[i] = 0;
            m_act = 0; e_drv = 0; m_base = 0; m_cnt = 0; e_dq = 0;
            p_ps = 0; p_cs = 0; p_adv = 0; p_a = 0; p_b = 0; p_c = 0;
            p_le = 0; p_wa = 0; p_lin = 0; p_addr = 0; p_wd = 0; p_lw = 0;
            return;
        end
        sel  = p_a && p_b && !p_c;
        go_p = p_ps && p_a;
        mask = p_wa ? 4'hF : (p_le ? p_lw : 4'h0);
        have = 0;
        if (go_p || p_cs) begin
            if (sel) begin
                m_act = 1; m_base = p_addr; m_cnt = 0; have = 1;
                if (go_p) mask = 0;
            end else m_act = 0;
        end else if (m_act) begin
            if (p_adv) m_cnt = (m_cnt + 1) % 4;
            have = 1;
        end
        lo = p_lin ? (m_base[1:0] + m_cnt) % 4 : (m_base[1:0] ^ m_cnt);
        a  = {m_base[5:2], 2'(lo)};
        e_drv = 0;
        if (have) begin
            if (mask != 0) begin
                for (int l = 0; l < 4; l++)
                    if (mask[l]) mm[a][l*8 +: 8] = p_wd[l*8 +: 8];
            end else begin
                e_drv = 1; e_dq = mm[a];
            end
        end
        p_ps = proc_strobe; p_cs = ctrl_strobe; p_adv = burst_adv;
        p_a = en_a; p_b = en_b; p_c = en_c_n; p_le = lane_wr_en; p_wa = wr_all;
        p_lin = burst_linear; p_addr = addr; p_wd = wdata; p_lw = lane_we;
    endtask

    task automatic compare();
        bit d;
        d = out_en && e_drv;
        chk(cur, {31'd0, rd_drive}, {31'd0, d});
        chk(cur, rd_data, d ? e_dq : 32'd0);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        proc_strobe = 0; ctrl_strobe = 0; burst_adv = 0; lane_wr_en = 0;
        wr_all = 0; lane_we = 0; en_a = 1; en_b = 1; en_c_n = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_edge();
        repeat (3) step();
        cur = "R1";
        chk("R1", {31'd0, rd_drive}, 32'd0);
        chk("R1", rd_data, 32'd0);
        @(negedge clk); rst_n = 1;
        step(); step();
        chk("R1", {31'd0, rd_drive}, 32'd0);

        // R13 / R7: controller-strobe write burst 8..11, all lanes.
        cur = "R13";
        ctrl_strobe = 1; addr = 8; burst_linear = 1; wr_all = 1; wdata = word(8);
        step();
        ctrl_strobe = 0; burst_adv = 1;
        for (int i = 9; i <= 11; i++) begin wdata = word(i); step(); end
        quiet(); step();
        chk("R7", {31'd0, rd_drive}, 32'd0);
        step();

        // R2 / R3: interleaved read burst from 9 -> 9,8,11,10.
        cur = "R3";
        proc_strobe = 1; addr = 9; burst_linear = 0;
        step();
        proc_strobe = 0; burst_adv = 1;
        step(); chk("R2", rd_data, word(9)); chk("R2", {31'd0, rd_drive}, 32'd1);
        step(); chk("R3", rd_data, word(8));
        step(); chk("R3", rd_data, word(11));
        burst_adv = 0;
        step(); chk("R3", rd_data, word(10));
        // R6: suspend repeats.
        cur = "R6";
        step(); chk("R6", rd_data, word(10));
        step(); chk("R6", rd_data, word(10));

        // R4 / R5: linear from 10 -> 10,11,8,9,10,11.
        cur = "R4";
        proc_strobe = 1; addr = 10; burst_linear = 1;
        step();
        proc_strobe = 0; burst_adv = 1;
        step(); chk("R4", rd_data, word(10));
        step(); chk("R4", rd_data, word(11));
        step(); chk("R4", rd_data, word(8));
        step(); chk("R4", rd_data, word(9));
        cur = "R5";
        step(); chk("R5", rd_data, word(10));
        burst_adv = 0;
        step(); chk("R5", rd_data, word(11));
        quiet(); step();

        // R8: processor strobe with writes asserted stays a read.
        cur = "R8";
        proc_strobe = 1; addr = 8; wr_all = 1; lane_wr_en = 1; lane_we = 4'hF;
        wdata = 32'hDEAD_BEEF;
        step(); quiet();
        step(); chk("R8", rd_data, word(8));
        ctrl_strobe = 1; addr = 8;
        step(); quiet();
        step(); chk("R8", rd_data, word(8));

        // R9: processor strobe with en_a low mid-burst is ignored.
        cur = "R9";
        proc_strobe = 1; addr = 9; burst_linear = 0;
        step();
        burst_adv = 1; en_a = 0; addr = 40;
        step(); chk("R9", rd_data, word(9));
        en_a = 1; proc_strobe = 0;
        step(); chk("R9", rd_data, word(8));
        quiet();
        step(); chk("R9", rd_data, word(11));

        // R10: deselect through en_b, then advance does nothing.
        cur = "R10";
        ctrl_strobe = 1; en_b = 0;
        step(); quiet();
        step(); chk("R10", {31'd0, rd_drive}, 32'd0);
        burst_adv = 1;
        step(); step(); chk("R10", {31'd0, rd_drive}, 32'd0);
        quiet();
        proc_strobe = 1; addr = 9; en_c_n = 1;
        step(); quiet();
        step(); chk("R10", {31'd0, rd_drive}, 32'd0);

        // R7: byte lanes 0 and 2 only; then lane select without enable reads.
        cur = "R7";
        ctrl_strobe = 1; addr = 20; lane_wr_en = 1; lane_we = 4'b0101;
        wdata = 32'hAABB_CCDD;
        step();
        lane_wr_en = 0; lane_we = 4'hF;
        step(); quiet();
        step(); chk("R7", rd_data, 32'h00BB_00DD);

        // R12: write then immediate read of the same address.
        cur = "R12";
        ctrl_strobe = 1; addr = 30; wr_all = 1; wdata = 32'h1234_5678;
        step();
        wr_all = 0;
        step(); quiet();
        step(); chk("R12", rd_data, 32'h1234_5678);

        // R11: output enable acts without a clock edge.
        cur = "R11";
        #1 out_en = 0; #1;
        chk("R11", {31'd0, rd_drive}, 32'd0);
        chk("R11", rd_data, 32'd0);
        out_en = 1; #1;
        chk("R11", rd_data, 32'h1234_5678);
        @(negedge clk);

        // Mixed random traffic against the model.
        cur = "R2";
        for (int i = 0; i < 600; i++) begin
            proc_strobe  = ($urandom % 6) == 0;
            ctrl_strobe  = ($urandom % 6) == 0;
            burst_adv    = $urandom % 2;
            en_a         = ($urandom % 8) != 0;
            en_b         = ($urandom % 8) != 0;
            en_c_n       = ($urandom % 8) == 0;
            lane_wr_en   = ($urandom % 3) == 0;
            wr_all       = ($urandom % 6) == 0;
            lane_we      = 4'($urandom);
            burst_linear = $urandom % 2;
            out_en       = ($urandom % 10) != 0;
            addr         = 6'($urandom);
            wdata        = $urandom;
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule